// File: doc/BRIEF.md
# Parking Bus Arbiter with Processor Timeslice

This block is the central arbiter of a shared parallel bus with nine request/grant pairs, numbered 0 to 8. Each agent asks for the bus by pulling its active-low request line low. The arbiter answers by pulling exactly one active-low grant line low. When nobody asks, the grant stays on the agent that held it last, so a driver is always present on the bus. Out of reset the bus belongs to port 0.

Port 8 serves a processor that issues short bursts. Each time port 8 gains the bus, a programmable timeslice starts, and during it the grant does not move, however many other agents ask. This lets the processor chain several small transactions. The processor can also hold a lock for an atomic sequence, and no other agent gets the bus while the lock is held. Otherwise the grant rotates among the requesters in round-robin order. The grant moves only between transactions, or after the current owner has withdrawn its request.

Top module: `park_arb`

## Requirements
- R1: While reset is active, and after reset with no request pending, only gnt_n[0] is low. Port 0 is the default park agent.
- R2: In every cycle exactly one bit of gnt_n is low.
- R3: In a cycle with all req_n bits high, the grant seen after the next clock edge is the same as the current one. The bus stays parked on its last owner.
- R4: When the grant may move, the new owner is the first requesting index found by searching upward from the current owner plus one, wrapping from 8 to 0. The current owner is considered last. The new grant appears one clock after the decision cycle.
- R5: While the bus is busy (frame_n or irdy_n low) and the owner still holds its request low, the grant does not move. If the owner raises its request while the bus is busy, the grant may move.
- R6: When port 8 is newly granted with slice_len = L, its grant stays low for at least L+1 consecutive cycles, even when other agents are requesting. With L = 0 it can lose the grant at the next decision and hold for only 1 cycle.
- R7: In any cycle where port 8 owns the bus and lock_req is high, the grant stays on port 8 at the next edge. In the first cycle where lock_req is low, normal arbitration resumes.
- R8: lock_req has no effect while another port owns the bus. Arbitration continues as if lock_req were low.
- R9: The timeslice length is captured from slice_len on the clock edge that grants port 8. Changes to slice_len during the window do not shorten or lengthen that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_n | input | 9 | Active-low bus requests, bit i from agent i |
| frame_n | input | 1 | Active-low transaction-in-progress indication from the bus |
| irdy_n | input | 1 | Active-low initiator-ready indication from the bus |
| lock_req | input | 1 | Atomic lock request from the processor port (port 8) |
| slice_len | input | 8 | Minimum processor timeslice in clocks; 0 disables the window |
| gnt_n | output | 9 | Active-low bus grants, exactly one low |

## Verification
The bench builds the block with its defaults: nine agents, the processor on port 8, parking on port 0 and an 8-bit timeslice. With these values the search wraps from index 8 back to 0, which lets the bench check the wrap order directly. Timeslice values of 0, 2 and 3 keep each window short enough to count cycle by cycle. In one test slice_len is changed in the middle of a window, to show that the window length is captured when port 8 is granted.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Outcome of one arbitration decision
  typedef enum logic [1:0] {
    ARB_PARK = 2'd0,  // no requester: keep the last owner
    ARB_STAY = 2'd1,  // switch not allowed this cycle
    ARB_MOVE = 2'd2   // hand the bus to the picked requester
  } arb_act_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_AGENTS = 9,
  localparam int IW = $clog2(N_AGENTS)
) (
  input  logic [N_AGENTS-1:0] req,
  input  logic [IW-1:0]       last,
  output logic                found,
  output logic [IW-1:0]       pick
);

  // Search starts one above the last owner and ends on the owner itself
  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int i = 1; i <= N_AGENTS; i++) begin
      int unsigned idx;
      idx = int'(last) + i;
      if (idx >= N_AGENTS) idx = idx - N_AGENTS;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/arb_slice_timer.sv
module arb_slice_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [TMR_W-1:0] slice_len,
  output logic             active
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (run & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = slice_len;
    else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = run & (cnt_q != '0);

endmodule

// File: rtl/park_arb.sv
module park_arb
  import arb_pkg::*;
#(
  parameter int N_AGENTS = 9,
  parameter int CPU_IDX  = N_AGENTS - 1,
  parameter int PARK_IDX = 0,
  parameter int TMR_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                lock_req,
  input  logic [TMR_W-1:0]    slice_len,
  output logic [N_AGENTS-1:0] gnt_n
);

  localparam int IW = $clog2(N_AGENTS);
  localparam logic [IW-1:0] CPU_SEL  = IW'(CPU_IDX);
  localparam logic [IW-1:0] PARK_SEL = IW'(PARK_IDX);

  logic                rst_n_sync;
  logic [N_AGENTS-1:0] req;
  logic [IW-1:0]       owner_q, owner_d;
  logic                owner_en;
  logic                bus_idle, owner_req, cpu_own;
  logic                lock_hold, slice_hold, may_switch;
  logic                pick_found;
  logic [IW-1:0]       pick_idx;
  logic                cpu_enter;
  arb_act_e            act;
  logic [N_AGENTS-1:0] gnt_vec;

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign req       = ~req_n;
  assign bus_idle  = frame_n & irdy_n;
  assign owner_req = req[owner_q];
  assign cpu_own   = (owner_q == CPU_SEL);
  assign lock_hold = cpu_own & lock_req;

  arb_rr_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .req   (req),
    .last  (owner_q),
    .found (pick_found),
    .pick  (pick_idx)
  );

  assign may_switch = (bus_idle | ~owner_req) & ~lock_hold & ~slice_hold;

  // Decision
  always_comb begin
    if (!pick_found)     act = ARB_PARK;
    else if (!may_switch) act = ARB_STAY;
    else                 act = ARB_MOVE;
  end

  assign owner_en = (act == ARB_MOVE) && (pick_idx != owner_q);

  always_comb begin
    owner_d = owner_q;
    if (owner_en) owner_d = pick_idx;
  end

  assign cpu_enter = owner_en & (owner_d == CPU_SEL);

  arb_slice_timer #(.TMR_W(TMR_W)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load      (cpu_enter),
    .run       (cpu_own),
    .slice_len (slice_len),
    .active    (slice_hold)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)   owner_q <= PARK_SEL;
    else if (owner_en) owner_q <= owner_d;
  end

  always_comb begin
    gnt_vec = '0;
    gnt_vec[owner_q] = 1'b1;
  end

  assign gnt_n = ~gnt_vec;

endmodule

// File: rtl/park_arb_chk.sv
module park_arb_chk #(
  parameter int N_AGENTS = 9,
  parameter int CPU_IDX  = N_AGENTS - 1,
  parameter int TMR_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] req_n,
  input logic                frame_n,
  input logic                irdy_n,
  input logic                lock_req,
  input logic [TMR_W-1:0]    slice_len,
  input logic [N_AGENTS-1:0] gnt_n
);

  logic             cpu_g, prev_q, cpu_lost;
  logic [TMR_W:0]   run_q;
  logic [TMR_W-1:0] cap_q;

  assign cpu_g    = ~gnt_n[CPU_IDX];
  assign cpu_lost = prev_q & ~cpu_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= cpu_g;
      if (cpu_g && !prev_q) begin
        run_q <= {{TMR_W{1'b0}}, 1'b1};
        cap_q <= slice_len;
      end else if (cpu_g && (run_q != '1)) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) == 1); // R2

  AST_PARK_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (&req_n) |=> $stable(gnt_n)); // R3

  AST_MOVE_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gnt_n) |-> (|(~gnt_n & ~$past(req_n)))); // R4

  AST_BUSY_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(frame_n && irdy_n) && (|(~req_n & ~gnt_n))) |=> $stable(gnt_n)); // R5

  AST_SLICE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_lost |-> (run_q > {1'b0, cap_q})); // R6

  AST_LOCK_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_g && lock_req) |=> $stable(gnt_n)); // R7

endmodule

bind park_arb park_arb_chk #(
  .N_AGENTS (N_AGENTS),
  .CPU_IDX  (CPU_IDX),
  .TMR_W    (TMR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_n     (req_n),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .lock_req  (lock_req),
  .slice_len (slice_len),
  .gnt_n     (gnt_n)
);

// File: tb/park_arb_tb.sv
`timescale 1ns/1ps
module park_arb_tb;

  localparam int N = 9;
  localparam int TW = 8;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req_n;
  logic          frame_n, irdy_n, lock_req;
  logic [TW-1:0] slice_len;
  logic [N-1:0]  gnt_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  park_arb u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n     (req_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .lock_req  (lock_req),
    .slice_len (slice_len),
    .gnt_n     (gnt_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_req(input logic [N-1:0] mask);
    req_n = ~mask;
  endtask

  task automatic chk_owner(input string tag, input int exp);
    logic [N-1:0] e;
    e = '1;
    e[exp] = 1'b0;
    n_chk++;
    if (gnt_n !== e) begin
      n_bad++;
      $display("FAIL %s: gnt_n=%b expected %b", tag, gnt_n, e);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    lock_req = 1'b0; slice_len = '0;
    tick(3);
    chk_owner("R1 during reset", 0);
    rst_n = 1'b1;
    tick(4);
    chk_owner("R1 after reset idle", 0);
  endtask

  task automatic t_park();
    tick(5);
    chk_owner("R3 park on default", 0);
    n_chk++;
    if ($countones(~gnt_n) != 1) begin
      n_bad++;
      $display("FAIL R2: grants low=%0d expected 1", $countones(~gnt_n));
    end
  endtask

  task automatic t_rr();
    set_req(9'h028);            // agents 3 and 5
    tick(1); chk_owner("R4 first after 0", 3);
    tick(1); chk_owner("R4 rotate to 5", 5);
    tick(1); chk_owner("R4 wrap back to 3", 3);
    set_req('0);
    tick(2); chk_owner("R3 park on last owner", 3);
    set_req(9'h004);            // agent 2, reached through wrap 8->0
    tick(1); chk_owner("R4 wrap 8 to 0 search", 2);
    set_req('0);
    tick(1);
  endtask

  task automatic t_busy();
    frame_n = 1'b0;
    set_req(9'h044);            // owner 2 and agent 6
    tick(3); chk_owner("R5 hold while busy", 2);
    set_req(9'h040);            // owner drops request
    tick(1); chk_owner("R5 move after owner drop", 6);
    frame_n = 1'b1;
    set_req('0);
    tick(1);
  endtask

  task automatic t_slice();
    slice_len = 8'd3;
    set_req(9'h100);
    tick(1); chk_owner("R6 cpu granted", 8);
    set_req(9'h002);            // agent 1 waits
    for (int k = 1; k <= 3; k++) begin
      tick(1); chk_owner($sformatf("R6 slice cycle %0d", k), 8);
    end
    tick(1); chk_owner("R6 release after L+1", 1);
    set_req('0);
    tick(1);
  endtask

  task automatic t_slice_zero();
    slice_len = 8'd0;
    set_req(9'h100);
    tick(1); chk_owner("R6 cpu granted L=0", 8);
    set_req(9'h010);
    tick(1); chk_owner("R6 L=0 immediate release", 4);
    set_req('0);
    tick(1);
  endtask

  task automatic t_lock();
    slice_len = 8'd0;
    set_req(9'h100);
    tick(1); chk_owner("R7 cpu granted", 8);
    lock_req = 1'b1;
    set_req(9'h080);
    tick(4); chk_owner("R7 hold under lock", 8);
    lock_req = 1'b0;
    tick(1); chk_owner("R7 move after release", 7);
  endtask

  task automatic t_lock_ignored();
    lock_req = 1'b1;
    set_req(9'h001);
    tick(1); chk_owner("R8 lock ignored off cpu", 0);
    lock_req = 1'b0;
    set_req('0);
    tick(1);
  endtask

  task automatic t_reload();
    slice_len = 8'd2;
    set_req(9'h100);
    tick(1); chk_owner("R9 cpu granted L=2", 8);
    slice_len = 8'd0;
    set_req(9'h008);
    tick(1); chk_owner("R9 window kept k1", 8);
    tick(1); chk_owner("R9 window kept k2", 8);
    tick(1); chk_owner("R9 release at k3", 3);
    set_req('0);
    tick(1);
  endtask

  initial begin
    t_reset();
    t_park();
    t_rr();
    t_busy();
    t_slice();
    t_slice_zero();
    t_lock();
    t_lock_ignored();
    t_reload();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule